// File: doc/BRIEF.md
# Outer-Product Byte Matrix Multiplier

This block multiplies two square matrices of unsigned bytes, of order 1, 2 or 3, chosen when a run starts. The operands sit in two on-chip stores, one for each matrix, that the host fills through a plain write-enable port while the block is idle. A run then walks the inner index: each step fetches a whole column of A and the matching row of B in one read. A grid of multipliers forms every pairwise product of the two vectors, and each product goes into its own accumulator. Every output element therefore gains one partial-product term per step, and each stored operand byte is fetched once per run.

Once the last step has been accumulated, a sequencer streams the results to an external result memory in row-major order, one element per cycle, and then raises a one-cycle completion pulse.

A uses a column-major layout and B a row-major layout, each with a fixed stride of three, so that one column of A or one row of B is a contiguous range of three bytes and comes out in a single wide read.

Top module: `mm_outer_top`

## Requirements
- R1: After reset, busy, done and res_we are all 0.
- R2: While idle, a cycle with ld_we=1 writes ld_a_data to the A store at ld_a_addr and ld_b_data to the B store at ld_b_addr. Element A[i][k] lives at address 3*k+i and B[k][j] at 3*k+j.
- R3: A start pulse while idle with order in 1..3 samples order and clears all accumulators, and busy is 1 in the next cycle. A start pulse with order 0 is ignored: busy stays 0 and nothing is written.
- R4: A run of order N reads operand word k (column k of A, row k of B) once for k = 0..N-1 in consecutive cycles. The first result write is seen N+1 cycles after the clock edge that sampled start.
- R5: Each result equals C[i][j] = sum over k of A[i][k]*B[k][j], exact as an 18-bit unsigned value. This includes all-255 operands at N=3, which give 195075.
- R6: Write-back issues exactly N*N writes in consecutive cycles with res_we=1, at addresses i*N+j in increasing row-major order.
- R7: done is high for exactly one cycle, the cycle right after the last result write, and busy is 0 in that cycle.
- R8: start and order are ignored while busy, and the running computation keeps its order.
- R9: ld_we is ignored while busy, and the stores keep their contents.
- R10: A run started right after another gives results that contain nothing from the earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Store write enable (idle only) |
| ld_a_addr | input | 4 | A store write address |
| ld_a_data | input | 8 | A store write byte |
| ld_b_addr | input | 4 | B store write address |
| ld_b_data | input | 8 | B store write byte |
| start | input | 1 | Begin a run |
| order | input | 2 | Matrix order N, sampled at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 4 | Result address i*N+j |
| res_data | output | 18 | Result element value |

## Verification
The bench aims at the order boundaries. At N=1 a design that forgets to stop the operand fetch, or that uses a stale lane, writes extra elements or wrong values. At N=2, a design that takes the row-major result address with the fixed stride of three instead of N writes to the wrong addresses. All-255 operands push the accumulators to their maximum, so an accumulator that is too narrow or a product that is truncated wraps around. Back-to-back runs show accumulators that are never cleared, because the earlier sums are added in.

Start, order and load writes driven in the middle of a run check the busy guards. A design that lets them through either restarts with a different order, which shows up as wrong addresses and completion timing, or corrupts an operand, which shows up in the next run's results. Counting cycles from start to the first write and to done catches an extra or missing read step in the pipeline.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_WB    = 2'd3
    } mm_state_e;
endpackage

// File: rtl/mm_bank.sv
module mm_bank #(
    parameter int NMAX = 3,
    parameter int DW   = 8,
    localparam int DEPTH = NMAX * NMAX,
    localparam int AIW   = $clog2(DEPTH),
    localparam int OW    = $clog2(NMAX + 1)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [AIW-1:0]               wr_addr,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    input  logic [OW-1:0]                rd_word,
    output logic [NMAX-1:0][DW-1:0]      rd_data
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [NMAX-1:0][DW-1:0] rd_q;

    // write has priority; a read returns one whole stride-NMAX word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (int'(wr_addr) < DEPTH)
                mem_q[wr_addr] <= wr_data;
        end else if (rd_en) begin
            for (int l = 0; l < NMAX; l++)
                rd_q[l] <= mem_q[int'(rd_word) * NMAX + l];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/mm_grid.sv
module mm_grid #(
    parameter int NMAX  = 3,
    parameter int DW    = 8,
    parameter int ACC_W = 18,
    localparam int OW   = $clog2(NMAX + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   clr,
    input  logic                                   acc_en,
    input  logic [OW-1:0]                          n_act,
    input  logic [NMAX-1:0][DW-1:0]                a_col,
    input  logic [NMAX-1:0][DW-1:0]                b_row,
    output logic [NMAX-1:0][NMAX-1:0][ACC_W-1:0]   acc
);
    logic [NMAX-1:0][NMAX-1:0][ACC_W-1:0] prod;
    logic [NMAX-1:0][NMAX-1:0][ACC_W-1:0] acc_d, acc_q;

    // one single-cycle multiplier per output element
    for (genvar gi = 0; gi < NMAX; gi++) begin : g_row
        for (genvar gj = 0; gj < NMAX; gj++) begin : g_col
            assign prod[gi][gj] = ACC_W'(a_col[gi]) * ACC_W'(b_row[gj]);

            // R5: a live accumulator only grows while summing a run
            a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_en && !clr) |=> (acc_q[gi][gj] >= $past(acc_q[gi][gj])));
        end
    end

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (acc_en) begin
            for (int i = 0; i < NMAX; i++)
                for (int j = 0; j < NMAX; j++)
                    if (i < int'(n_act) && j < int'(n_act))
                        acc_d[i][j] = acc_q[i][j] + prod[i][j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R3: a clear leaves every accumulator at zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int NMAX = 3,
    localparam int OW  = $clog2(NMAX + 1),
    localparam int AIW = $clog2(NMAX * NMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OW-1:0]   order,
    output logic            rd_en,
    output logic [OW-1:0]   rd_word,
    output logic            acc_clr,
    output logic            acc_en,
    output logic [OW-1:0]   n_act,
    output logic [OW-1:0]   wb_row,
    output logic [OW-1:0]   wb_col,
    output logic            res_we,
    output logic [AIW-1:0]  res_addr,
    output logic            busy,
    output logic            done
);
    typedef struct packed {
        mm_state_e     st;
        logic [OW-1:0] k;
        logic [OW-1:0] n;
        logic [OW-1:0] wi;
        logic [OW-1:0] wj;
        logic          rvalid;
        logic          done;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  last_k, last_wb;

    assign last_k  = (c_q.k  == c_q.n - OW'(1));
    assign last_wb = (c_q.wi == c_q.n - OW'(1)) && (c_q.wj == c_q.n - OW'(1));

    always_comb begin
        c_d        = c_q;
        c_d.done   = 1'b0;
        c_d.rvalid = 1'b0;
        rd_en      = 1'b0;
        acc_clr    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start && order != '0 && int'(order) <= NMAX) begin
                    c_d.n   = order;
                    c_d.k   = '0;
                    c_d.st  = ST_FETCH;
                    acc_clr = 1'b1;
                end
            end
            ST_FETCH: begin
                rd_en      = 1'b1;
                c_d.rvalid = 1'b1;
                if (last_k) c_d.st = ST_DRAIN;
                else        c_d.k  = c_q.k + OW'(1);
            end
            ST_DRAIN: begin
                c_d.st = ST_WB;
                c_d.wi = '0;
                c_d.wj = '0;
            end
            ST_WB: begin
                if (c_q.wj == c_q.n - OW'(1)) begin
                    c_d.wj = '0;
                    if (last_wb) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.wi = c_q.wi + OW'(1);
                    end
                end else begin
                    c_d.wj = c_q.wj + OW'(1);
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign rd_word  = c_q.k;
    assign acc_en   = c_q.rvalid;
    assign n_act    = c_q.n;
    assign wb_row   = c_q.wi;
    assign wb_col   = c_q.wj;
    assign res_we   = (c_q.st == ST_WB);
    assign res_addr = AIW'(int'(c_q.wi) * int'(c_q.n) + int'(c_q.wj));
    assign busy     = (c_q.st != ST_IDLE);
    assign done     = c_q.done;

    // R4: operand words are fetched in strictly increasing order, once each
    a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FETCH && !last_k) |=> (c_q.k == $past(c_q.k) + OW'(1)));

    // R7: completion follows the final result write
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && last_wb) |=> (done && !busy));

    // R7: done never lasts two cycles
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the sampled order holds for the whole run
    a_r8_order_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(c_q.n));

    // R6: result addresses stay inside the N*N block
    a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (int'(res_addr) < int'(c_q.n) * int'(c_q.n)));
endmodule

// File: rtl/mm_outer_top.sv
module mm_outer_top #(
    parameter int NMAX  = 3,
    parameter int DW    = 8,
    parameter int ACC_W = 18,
    localparam int AIW  = $clog2(NMAX * NMAX),
    localparam int OW   = $clog2(NMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [AIW-1:0]   ld_a_addr,
    input  logic [DW-1:0]    ld_a_data,
    input  logic [AIW-1:0]   ld_b_addr,
    input  logic [DW-1:0]    ld_b_data,
    input  logic             start,
    input  logic [OW-1:0]    order,
    output logic             busy,
    output logic             done,
    output logic             res_we,
    output logic [AIW-1:0]   res_addr,
    output logic [ACC_W-1:0] res_data
);
    logic                                 rd_en, acc_clr, acc_en, wr_ok;
    logic [OW-1:0]                        rd_word, n_act, wb_row, wb_col;
    logic [NMAX-1:0][DW-1:0]              a_col, b_row;
    logic [NMAX-1:0][NMAX-1:0][ACC_W-1:0] acc;

    assign wr_ok = ld_we && !busy;

    mm_bank #(.NMAX(NMAX), .DW(DW)) u_bank_a (
        .clk(clk), .wr_en(wr_ok), .wr_addr(ld_a_addr), .wr_data(ld_a_data),
        .rd_en(rd_en), .rd_word(rd_word), .rd_data(a_col)
    );

    mm_bank #(.NMAX(NMAX), .DW(DW)) u_bank_b (
        .clk(clk), .wr_en(wr_ok), .wr_addr(ld_b_addr), .wr_data(ld_b_data),
        .rd_en(rd_en), .rd_word(rd_word), .rd_data(b_row)
    );

    mm_grid #(.NMAX(NMAX), .DW(DW), .ACC_W(ACC_W)) u_grid (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .acc_en(acc_en),
        .n_act(n_act), .a_col(a_col), .b_row(b_row), .acc(acc)
    );

    mm_ctrl #(.NMAX(NMAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .order(order),
        .rd_en(rd_en), .rd_word(rd_word), .acc_clr(acc_clr), .acc_en(acc_en),
        .n_act(n_act), .wb_row(wb_row), .wb_col(wb_col),
        .res_we(res_we), .res_addr(res_addr), .busy(busy), .done(done)
    );

    assign res_data = acc[wb_row][wb_col];

    // R9: no store write is accepted during a run
    a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ok);

    // R1: outputs are quiet straight after reset
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done && !res_we));
endmodule

// File: tb/mm_outer_top_test.sv
module mm_outer_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_a_addr = '0, ld_b_addr = '0;
    logic [7:0]  ld_a_data = '0, ld_b_data = '0;
    logic        start = 1'b0;
    logic [1:0]  order = '0;
    logic        busy, done, res_we;
    logic [3:0]  res_addr;
    logic [17:0] res_data;

    int total = 0;
    int bad = 0;
    int ma [3][3];
    int mb [3][3];
    string cur_tag = "R5";

    typedef struct { int addr; int data; } exp_t;
    exp_t sbq [$];

    always #2 clk = ~clk;

    mm_outer_top uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we),
        .ld_a_addr(ld_a_addr), .ld_a_data(ld_a_data),
        .ld_b_addr(ld_b_addr), .ld_b_data(ld_b_data),
        .start(start), .order(order), .busy(busy), .done(done),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data)
    );

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop and compare each result write
    always @(negedge clk) begin
        if (rst_n && res_we) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R6 unexpected result write", int'(res_addr), -1);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(int'(res_addr) == e.addr, {"R6 address ", cur_tag}, int'(res_addr), e.addr);
                check(int'(res_data) == e.data, {"R5 data ", cur_tag}, int'(res_data), e.data);
            end
        end
    end

    // R2: A[i][k] at 3k+i, B[k][j] at 3k+j
    task automatic load_all();
        for (int adr = 0; adr < 9; adr++) begin
            @(negedge clk);
            ld_we     = 1'b1;
            ld_a_addr = 4'(adr);
            ld_a_data = 8'(ma[adr % 3][adr / 3]);
            ld_b_addr = 4'(adr);
            ld_b_data = 8'(mb[adr / 3][adr % 3]);
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++) begin
                ma[i][j] = int'($urandom_range(0, 255));
                mb[i][j] = int'($urandom_range(0, 255));
            end
    endtask

    task automatic run(int n, bit interfere, string tag);
        int t;
        int first;
        cur_tag = tag;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n; j++) begin
                exp_t e;
                int s;
                s = 0;
                for (int k = 0; k < n; k++) s += ma[i][k] * mb[k][j];
                e.addr = i * n + j;
                e.data = s;
                sbq.push_back(e);
            end
        @(negedge clk);
        start = 1'b1;
        order = 2'(n);
        @(negedge clk);
        start = 1'b0;
        t = 1;
        first = -1;
        check(busy == 1'b1, {"R3 busy after start ", tag}, int'(busy), 1);
        while (!done && t < 100) begin
            if (res_we && first < 0) first = t;
            @(negedge clk);
            t++;
            if (interfere && t == 2) begin
                start     = 1'b1;
                order     = 2'(n == 1 ? 3 : 1);
                ld_we     = 1'b1;
                ld_a_addr = 4'd0;
                ld_a_data = ~8'(ma[0][0]);
                ld_b_addr = 4'd4;
                ld_b_data = ~8'(mb[1][1]);
            end else if (interfere && t == 3) begin
                start = 1'b0;
                ld_we = 1'b0;
            end
        end
        check(first == n + 2, {"R4 first write latency ", tag}, first, n + 2);
        check(t == n * n + n + 2, {"R7 done timing ", tag}, t, n * n + n + 2);
        check(busy == 1'b0, {"R7 busy low with done ", tag}, int'(busy), 0);
        check(sbq.size() == 0, {"R6 all writes seen ", tag}, sbq.size(), 0);
        @(negedge clk);
        check(done == 1'b0, {"R7 done one cycle ", tag}, int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0,   "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0,   "R1 done after reset", int'(done), 0);
        check(res_we == 1'b0, "R1 res_we after reset", int'(res_we), 0);

        fill_rand();
        load_all();
        run(3, 1'b0, "R2 N=3");
        run(2, 1'b0, "R2 N=2");
        run(1, 1'b0, "N=1");
        run(3, 1'b0, "R10 back-to-back");

        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++) begin
                ma[i][j] = 255;
                mb[i][j] = 255;
            end
        load_all();
        run(3, 1'b0, "R5 all-255");

        fill_rand();
        load_all();
        run(3, 1'b0, "N=3 fresh");
        run(2, 1'b1, "R8 start/order mid-run");
        run(3, 1'b0, "R9 stores after mid-run load");

        // R3: order 0 is not a valid start
        @(negedge clk);
        start = 1'b1;
        order = 2'd0;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R3 order 0 ignored", int'(busy), 0);
        repeat (6) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R3 order 0 stays idle", int'(busy || done), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule